// File: doc/BRIEF.md
# Reset-Aligned Rate Divider with Input Word Capture

This block sits in front of a DAC data register when the converter is clocked directly from an external fast clock. The fast clock runs at twice the sample rate, or at four times the rate when every interpolated sample is followed by an inserted midscale sample. The block divides the fast clock down to the sample-rate clock and brings it out as a monitor output. It also decides on which fast edge an incoming data word is captured and flags the cycle in which the DAC register holds a new word.

An asynchronous alignment input lets the external data source fix the divider phase. While alignment is held, the sample-rate clock is forced high. Its release passes through a two-flop synchroniser. After that the phase always advances in the same way: first a low phase, then the rising edge that captures the first word. The source therefore knows exactly which fast edge takes its data.

Top module: `dac_clk_align`

## Requirements
- R1: While rst_ni is low, clk1x_o is 1, latch_en_o and dac_upd_o are 0 and dac_o is 0.
- R2: Raising align_i forces clk1x_o to 1 and latch_en_o to 0 at once, without waiting for a clock edge, and both stay so while align_i is high.
- R3: After align_i falls, two fast edges pass through the synchroniser with clk1x_o still 1. The third fast edge drives clk1x_o to 0.
- R4: With quad_mode_i = 0 and alignment released, clk1x_o toggles on every fast rising edge. The first capture happens on the fourth fast edge after release.
- R5: latch_en_o is a one-cycle pulse, high exactly in the fast cycle whose closing edge raises clk1x_o. The data_i value present at that edge is captured.
- R6: dac_upd_o is high for one cycle right after a capturing edge, and during that cycle dac_o equals the captured word.
- R7: dac_o changes only on capturing edges and holds its value otherwise.
- R8: With quad_mode_i = 1, clk1x_o repeats low, low, high, high over four fast cycles. After release, edges 3 and 4 give low and edge 5 raises it with the first capture.
- R9: If align_i is raised in a cycle where a capture was due, no capture occurs, dac_o keeps its value and dac_upd_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, 2x or 4x the sample rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| align_i | input | 1 | Active-high asynchronous phase alignment request |
| quad_mode_i | input | 1 | 0: fast clock is 2x the sample rate, 1: 4x |
| data_i | input | DATA_W | Incoming sample word |
| clk1x_o | output | 1 | Sample-rate clock monitor |
| latch_en_o | output | 1 | High in the cycle whose closing edge captures data_i |
| dac_upd_o | output | 1 | High in the cycle after a capture |
| dac_o | output | DATA_W | DAC register contents |

## Verification
The assertions assume that quad_mode_i changes only while align_i is high, so that the phase counter is never left at a value the other ratio does not use. The bench meets this by choosing a new ratio only at the same falling edge that raises align_i, and by keeping it until the next alignment pulse. Alignment pulses and data changes happen at falling clock edges, with random lengths. A directed segment raises align_i in exactly the cycle where a capture is due.

// File: rtl/dac_clk_align_pkg.sv
package dac_clk_align_pkg;
  localparam int MAX_RATIO = 4;
  localparam int PH_W      = $clog2(MAX_RATIO);

  typedef logic [PH_W-1:0] phase_t;

  // phase loaded while aligning: last high phase of the ratio
  function automatic phase_t ph_load(input logic quad);
    return quad ? phase_t'(1) : phase_t'(0);
  endfunction

  // phase whose closing edge raises the 1x clock
  function automatic phase_t ph_last(input logic quad);
    return quad ? phase_t'(MAX_RATIO - 1) : phase_t'(1);
  endfunction
endpackage

// File: rtl/align_sync.sv
module align_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic align_i,
  output logic hold_o
);
  logic             set_async;
  logic [STAGES-1:0] sh_q;

  assign set_async = align_i | ~rst_ni;

  // assert asynchronously, release through STAGES flops
  always_ff @(posedge clk_i or posedge set_async) begin
    if (set_async) sh_q <= '1;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign hold_o = sh_q[STAGES-1];
endmodule

// File: rtl/phase_div.sv
module phase_div
  import dac_clk_align_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic quad_i,
  output logic clk1x_o,
  output logic latch_en_o
);
  phase_t ph_q, ph_d;
  logic   ph_high;

  always_comb begin
    if (hold_i)      ph_d = ph_load(quad_i);
    else if (quad_i) ph_d = ph_q + phase_t'(1);
    else             ph_d = {{(PH_W-1){1'b0}}, ~ph_q[0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign ph_high    = quad_i ? ~ph_q[PH_W-1] : ~ph_q[0];
  assign clk1x_o    = hold_i | ph_high;
  assign latch_en_o = ~hold_i & (ph_q == ph_last(quad_i));
endmodule

// File: rtl/word_capture.sv
module word_capture #(
  parameter int DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              dac_upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_o     <= '0;
      dac_upd_o <= 1'b0;
    end else begin
      dac_upd_o <= latch_en_i;
      if (latch_en_i) dac_o <= data_i;
    end
  end
endmodule

// File: rtl/dac_clk_align.sv
module dac_clk_align #(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              align_i,
  input  logic              quad_mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              clk1x_o,
  output logic              latch_en_o,
  output logic              dac_upd_o,
  output logic [DATA_W-1:0] dac_o
);
  logic hold_q;

  align_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .align_i (align_i),
    .hold_o  (hold_q)
  );

  phase_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold_q),
    .quad_i     (quad_mode_i),
    .clk1x_o    (clk1x_o),
    .latch_en_o (latch_en_o)
  );

  word_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_en_i (latch_en_o),
    .data_i     (data_i),
    .dac_o      (dac_o),
    .dac_upd_o  (dac_upd_o)
  );
endmodule

// File: rtl/dac_clk_align_chk.sv
module dac_clk_align_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              align_i,
  input logic              quad_mode_i,
  input logic              hold_i,
  input logic              clk1x_o,
  input logic              latch_en_o,
  input logic              dac_upd_o,
  input logic [DATA_W-1:0] dac_o
);
  AST_ALIGN_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_i |-> (clk1x_o && !latch_en_o)); // R2

  AST_RELEASE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |-> (clk1x_o && !latch_en_o)); // R3

  AST_RELEASE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |=> (!clk1x_o || hold_i)); // R3

  AST_TOGGLE_2X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quad_mode_i && !hold_i && !$past(hold_i)) |-> (clk1x_o != $past(clk1x_o))); // R4

  AST_LATCH_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en_o |=> $rose(clk1x_o)); // R5

  AST_LATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en_o |=> !latch_en_o); // R5

  AST_UPD_AFTER_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en_o |=> dac_upd_o); // R6

  AST_UPD_ONLY_AFTER_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_upd_o |-> $past(latch_en_o)); // R6

  AST_DAC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_upd_o |-> $stable(dac_o)); // R7

  AST_QUAD_HIGH_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_mode_i && !hold_i && $rose(clk1x_o)) |=> clk1x_o); // R8

  AST_QUAD_LOW_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_mode_i && !hold_i && $fell(clk1x_o)) |=> (!clk1x_o || hold_i)); // R8
endmodule

bind dac_clk_align dac_clk_align_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .align_i     (align_i),
  .quad_mode_i (quad_mode_i),
  .hold_i      (hold_q),
  .clk1x_o     (clk1x_o),
  .latch_en_o  (latch_en_o),
  .dac_upd_o   (dac_upd_o),
  .dac_o       (dac_o)
);

// File: tb/dac_clk_align_test.sv
`timescale 1ns/1ps
module dac_clk_align_test;
  localparam int DW = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          align_i = 1'b1;
  logic          quad_mode_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          clk1x_o, latch_en_o, dac_upd_o;
  logic [DW-1:0] dac_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dac_clk_align #(.DATA_W(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .align_i(align_i), .quad_mode_i(quad_mode_i),
    .data_i(data_i), .clk1x_o(clk1x_o), .latch_en_o(latch_en_o),
    .dac_upd_o(dac_upd_o), .dac_o(dac_o)
  );

  // bench model: n = fast edges since align_i fell
  int            n = 0;
  bit            al = 1, quad = 0;
  bit            prev_lat = 0, exp_upd = 0;
  logic [DW-1:0] prev_data = '0, exp_word = '0;

  function automatic bit exp_clk(int e, bit q, bit a);
    int m;
    if (a || e <= 2) return 1'b1;
    m = e - 3;
    return q ? ((m % 4) >= 2) : ((m % 2) == 1);
  endfunction

  function automatic bit exp_lat(int e, bit q, bit a);
    int m;
    if (a || e < 3) return 1'b0;
    m = e - 3;
    return q ? ((m % 4) == 1) : ((m % 2) == 0);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit new_al, input bit new_quad);
    bit    rising, ec, el;
    string tc;
    @(posedge clk_i);
    exp_upd = prev_lat;
    if (prev_lat) exp_word = prev_data;
    if (al) n = 0; else n++;
    @(negedge clk_i);
    ec = exp_clk(n, quad, al);
    el = exp_lat(n, quad, al);
    tc = al ? "R2" : (n <= 3 ? "R3" : (quad ? "R8" : "R4"));
    check(clk1x_o === ec, {tc, " clk1x"}, clk1x_o, ec);
    check(latch_en_o === el, "R5 latch_en", latch_en_o, el);
    check(dac_upd_o === exp_upd, "R6 dac_upd", dac_upd_o, exp_upd);
    check(dac_o === exp_word, exp_upd ? "R6 dac word" : "R7 dac hold", dac_o, exp_word);
    rising = new_al && !al;
    al = new_al;
    quad = new_quad;
    align_i = al;
    quad_mode_i = quad;
    data_i = DW'($urandom);
    if (al) n = 0;
    if (rising) begin
      #0.5;
      check(clk1x_o === 1'b1, "R2 async force", clk1x_o, 1);
      check(latch_en_o === 1'b0, el ? "R9 capture cancelled" : "R2 latch gated", latch_en_o, 0);
    end
    prev_lat = exp_lat(n, quad, al);
    prev_data = data_i;
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    // R1: reset state
    #1;
    repeat (3) begin
      @(negedge clk_i);
      check(clk1x_o === 1'b1, "R1 clk1x", clk1x_o, 1);
      check(latch_en_o === 1'b0, "R1 latch_en", latch_en_o, 0);
      check(dac_upd_o === 1'b0, "R1 dac_upd", dac_upd_o, 0);
      check(dac_o === '0, "R1 dac", dac_o, 0);
    end
    rst_ni = 1'b1;
    repeat (3) step(1, 0);

    for (int seg = 0; seg < 60; seg++) begin
      bit q;
      int len;
      q   = (seg < 2) ? seg[0] : bit'($urandom_range(0, 1));
      len = $urandom_range(6, 40);
      step(1, q);                       // choose ratio while holding
      repeat ($urandom_range(0, 2)) step(1, q);
      if (seg == 2 || seg == 3) begin
        // R9: run until a capture is due, then raise align_i
        repeat (6) step(0, q);
        while (!prev_lat) step(0, q);
      end else begin
        repeat (len) step(0, q);
      end
    end
    step(1, 0);
    step(1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule